// File: doc/BRIEF.md
# Nonvolatile Command Sequence Detector

This block watches a clocked, sampled copy of an asynchronous byte-wide memory bus. It looks for a fixed series of six read accesses to special addresses. When the series completes, it raises a single-cycle request that starts either a save of the working array into nonvolatile storage or a restore from that storage.

Each access is counted once, on the falling edge of the active-low chip enable. The address and the write-enable level are taken at that edge. The first five accesses of the series are ordinary reads, and the memory still serves data for them. Only the sixth address chooses the command.

The transfer controller can hold the detector idle through a busy input. A power supervisor can block save requests through an inhibit input.

Top module: `nvcmd_detect`

## Requirements
- R1: A read series to 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then 0x70F raises `save_req_o` for exactly one clock. That clock is the one that follows the second rising edge, counting from the edge that first samples `cs_n_i` low on the sixth access.
- R2: The same five-read prefix followed by a read of 0x70E raises `restore_req_o` for one clock, with the timing of R1.
- R3: A step is counted only when `cs_n_i` goes from high to low. The address and `we_n_i` are taken from the first rising edge that samples `cs_n_i` low. An address change while `cs_n_i` stays low does not count as a step.
- R4: An access with `we_n_i` low aborts the series, wherever it occurs. A write to 0x000 does not start a new series.
- R5: A read of any address other than the expected next one aborts the series, and no request is issued. A sixth address other than 0x70F or 0x70E issues nothing.
- R6: A read of 0x000 that does not continue the series is taken as a new first step. The series can then complete without an idle access in between.
- R7: After the sixth access, with or without a request, the detector is back at the start. A further 0x555…0x70F run without a leading 0x000 issues nothing.
- R8: The level of `oe_n_i` has no effect on counting or on the requests.
- R9: While `busy_i` is high, the detector stays at the start and ignores every access. No request is raised in the clock after a cycle with `busy_i` high.
- R10: `save_inhibit_i` high suppresses the save request but leaves restore requests unaffected.
- R11: After reset both requests are low. The two requests are never high together, and neither stays high for two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 11 | Sampled bus address |
| cs_n_i | input | 1 | Sampled chip enable, active low |
| we_n_i | input | 1 | Sampled write enable, active low |
| oe_n_i | input | 1 | Sampled output enable, active low (ignored by default) |
| busy_i | input | 1 | Transfer controller busy; holds detector idle |
| save_inhibit_i | input | 1 | Supervisor blocks save requests |
| save_req_o | output | 1 | One-cycle save start pulse |
| restore_req_o | output | 1 | One-cycle restore start pulse |

## Verification
Call the rising edge that first samples chip enable low on an access edge E. The step registers at E, the matcher and the request flops update at E+1, and the request is therefore visible from E+1 until E+2. For every access, the driver queues an expected pulse pair tagged with cycle E+1. The monitor compares the outputs on the falling edge of that cycle. On every other falling edge, the monitor expects both outputs low. The busy and inhibit inputs are changed only between accesses, so their sampling edge is never in doubt.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned PREFIX_LEN = 5;
  localparam int unsigned POS_W      = $clog2(PREFIX_LEN + 1);
  localparam int unsigned NSLOT      = 2 ** POS_W;

  localparam logic [ADDR_W-1:0] SAVE_CODE    = 11'h70F;
  localparam logic [ADDR_W-1:0] RESTORE_CODE = 11'h70E;

  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } step_t;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_SAVE    = 2'd1,
    CMD_RESTORE = 2'd2
  } cmd_e;

  // Address expected at prefix position idx (0 = first access)
  function automatic logic [ADDR_W-1:0] prefix_code(input int unsigned idx);
    case (idx)
      0:       return 11'h000;
      1:       return 11'h555;
      2:       return 11'h2AA;
      3:       return 11'h7FF;
      4:       return 11'h0F0;
      default: return 11'h000;
    endcase
  endfunction
endpackage

// File: rtl/nvcmd_rst_sync.sv
module nvcmd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/nvcmd_step_sampler.sv
module nvcmd_step_sampler
  import nvcmd_pkg::*;
#(
  parameter bit OE_QUALIFY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  output step_t             step_o
);
  logic  cs_prev_q;
  logic  fall;
  logic  oe_ok;
  step_t step_d, step_q;

  always_comb begin
    fall        = cs_prev_q & ~cs_n_i;
    oe_ok       = OE_QUALIFY ? ~oe_n_i : 1'b1;
    step_d.vld  = fall & oe_ok;
    step_d.wr   = ~we_n_i;
    step_d.addr = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b1;
      step_q    <= '0;
    end else begin
      cs_prev_q <= cs_n_i;
      step_q    <= step_d;
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/nvcmd_step_matcher.sv
module nvcmd_step_matcher
  import nvcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_t step_i,
  input  logic  busy_i,
  output cmd_e  cmd_o
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic [NSLOT-1:0] pre_hit;
  logic             upd_en;
  logic             rd_vld;
  cmd_e             cmd_d;

  assign rd_vld = step_i.vld & ~step_i.wr;

  // One comparator per prefix position; unused slots never match
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < PREFIX_LEN) begin : g_cmp
      localparam logic [ADDR_W-1:0] CODE = prefix_code(i);
      assign pre_hit[i] = rd_vld & (step_i.addr == CODE);
    end else begin : g_pad
      assign pre_hit[i] = 1'b0;
    end
  end

  always_comb begin
    pos_d  = pos_q;
    cmd_d  = CMD_NONE;
    upd_en = busy_i | step_i.vld;
    if (busy_i) begin
      pos_d = '0;
    end else if (step_i.vld) begin
      if (step_i.wr) begin
        pos_d = '0;
      end else if (pos_q == POS_W'(PREFIX_LEN)) begin
        if (step_i.addr == SAVE_CODE)         cmd_d = CMD_SAVE;
        else if (step_i.addr == RESTORE_CODE) cmd_d = CMD_RESTORE;
        pos_d = pre_hit[0] ? POS_W'(1) : '0;
      end else if (pre_hit[pos_q]) begin
        pos_d = pos_q + POS_W'(1);
      end else if (pre_hit[0]) begin
        pos_d = POS_W'(1);
      end else begin
        pos_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (upd_en) pos_q <= pos_d;
  end

  assign cmd_o = cmd_d;
endmodule

// File: rtl/nvcmd_cmd_issue.sv
module nvcmd_cmd_issue
  import nvcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd_i,
  input  logic save_inhibit_i,
  output logic save_req_o,
  output logic restore_req_o
);
  logic save_d, restore_d;
  logic save_q, restore_q;

  always_comb begin
    save_d    = (cmd_i == CMD_SAVE) & ~save_inhibit_i;
    restore_d = (cmd_i == CMD_RESTORE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_q    <= 1'b0;
      restore_q <= 1'b0;
    end else begin
      save_q    <= save_d;
      restore_q <= restore_d;
    end
  end

  assign save_req_o    = save_q;
  assign restore_req_o = restore_q;
endmodule

// File: rtl/nvcmd_detect.sv
module nvcmd_detect
  import nvcmd_pkg::*;
#(
  parameter bit OE_QUALIFY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic              busy_i,
  input  logic              save_inhibit_i,
  output logic              save_req_o,
  output logic              restore_req_o
);
  logic  rst_n_s;
  step_t step;
  cmd_e  cmd;

  nvcmd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  nvcmd_step_sampler #(.OE_QUALIFY(OE_QUALIFY)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .addr_i (addr_i),
    .cs_n_i (cs_n_i),
    .we_n_i (we_n_i),
    .oe_n_i (oe_n_i),
    .step_o (step)
  );

  nvcmd_step_matcher u_match (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .step_i (step),
    .busy_i (busy_i),
    .cmd_o  (cmd)
  );

  nvcmd_cmd_issue u_issue (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .cmd_i          (cmd),
    .save_inhibit_i (save_inhibit_i),
    .save_req_o     (save_req_o),
    .restore_req_o  (restore_req_o)
  );
endmodule

// File: rtl/nvcmd_detect_chk.sv
module nvcmd_detect_chk
  import nvcmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cs_n_i,
  input logic              we_n_i,
  input logic              busy_i,
  input logic              save_inhibit_i,
  input logic              save_req_o,
  input logic              restore_req_o
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_req_o, restore_req_o})); // R11

  AST_SAVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    save_req_o |=> !save_req_o); // R1

  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req_o |=> !restore_req_o); // R2

  AST_SAVE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    save_req_o |-> ($past(addr_i, 2) == SAVE_CODE) && $past(we_n_i, 2)
                   && !$past(cs_n_i, 2) && $past(cs_n_i, 3)); // R3

  AST_RESTORE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req_o |-> ($past(addr_i, 2) == RESTORE_CODE) && $past(we_n_i, 2)
                      && !$past(cs_n_i, 2) && $past(cs_n_i, 3)); // R4

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !save_req_o && !restore_req_o); // R9

  AST_INHIBIT_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    save_inhibit_i |=> !save_req_o); // R10
endmodule

bind nvcmd_detect nvcmd_detect_chk u_chk (.*);

// File: tb/tb_nvcmd_detect.sv
`timescale 1ns/1ps
module tb_nvcmd_detect;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr_i;
  logic        cs_n_i, we_n_i, oe_n_i, busy_i, save_inhibit_i;
  logic        save_req_o, restore_req_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    int    due;
    bit    s;
    bit    r;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvcmd_detect dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i),
    .we_n_i(we_n_i), .oe_n_i(oe_n_i), .busy_i(busy_i),
    .save_inhibit_i(save_inhibit_i), .save_req_o(save_req_o),
    .restore_req_o(restore_req_o)
  );

  // Monitor: compare at the due cycle, demand silence elsewhere
  always @(negedge clk) begin
    if (mon_on) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (save_req_o !== e.s || restore_req_o !== e.r) begin
          bad++;
          $display("FAIL %s cyc=%0d actual save/restore=%b%b expected=%b%b",
                   e.tag, cyc, save_req_o, restore_req_o, e.s, e.r);
        end
      end else if (save_req_o !== 1'b0 || restore_req_o !== 1'b0) begin
        total++;
        bad++;
        $display("FAIL R11 cyc=%0d unexpected pulse actual=%b%b expected=00",
                 cyc, save_req_o, restore_req_o);
      end
    end
  end

  // Driver: one chip-enable access; E = edge that samples cs low, due E+1
  task automatic access(input logic [10:0] a, input bit wr, input bit s,
                        input bit r, input string tag, input bit wiggle = 1'b0);
    exp_t e;
    @(negedge clk);
    cs_n_i = 1'b0; addr_i = a; we_n_i = ~wr;
    e.due = cyc + 2; e.s = s; e.r = r; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    if (wiggle) addr_i = 11'h123;
    @(negedge clk);
    cs_n_i = 1'b1; we_n_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix(input string tag);
    access(11'h000, 0, 0, 0, tag);
    access(11'h555, 0, 0, 0, tag);
    access(11'h2AA, 0, 0, 0, tag);
    access(11'h7FF, 0, 0, 0, tag);
    access(11'h0F0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; cs_n_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b0;
    busy_i = 1'b0; save_inhibit_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (save_req_o !== 1'b0 || restore_req_o !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset actual=%b%b expected=00", save_req_o, restore_req_o);
    end
    mon_on = 1'b1;

    // R1 save series
    prefix("R1"); access(11'h70F, 0, 1, 0, "R1");
    // R2 restore series
    prefix("R2"); access(11'h70E, 0, 0, 1, "R2");
    // R3 address wiggle while chip enable held low does not add a step
    access(11'h000, 0, 0, 0, "R3");
    access(11'h555, 0, 0, 0, "R3", 1'b1);
    access(11'h2AA, 0, 0, 0, "R3");
    access(11'h7FF, 0, 0, 0, "R3");
    access(11'h0F0, 0, 0, 0, "R3");
    access(11'h70F, 0, 1, 0, "R3");
    // R4 write in the middle aborts
    access(11'h000, 0, 0, 0, "R4"); access(11'h555, 0, 0, 0, "R4");
    access(11'h2AA, 1, 0, 0, "R4"); access(11'h7FF, 0, 0, 0, "R4");
    access(11'h0F0, 0, 0, 0, "R4"); access(11'h70F, 0, 0, 0, "R4");
    // R4 write to 0x000 is no restart
    access(11'h000, 1, 0, 0, "R4"); access(11'h555, 0, 0, 0, "R4");
    access(11'h2AA, 0, 0, 0, "R4"); access(11'h7FF, 0, 0, 0, "R4");
    access(11'h0F0, 0, 0, 0, "R4"); access(11'h70E, 0, 0, 0, "R4");
    // R5 wrong address at step four
    access(11'h000, 0, 0, 0, "R5"); access(11'h555, 0, 0, 0, "R5");
    access(11'h2AA, 0, 0, 0, "R5"); access(11'h7FE, 0, 0, 0, "R5");
    access(11'h0F0, 0, 0, 0, "R5"); access(11'h70F, 0, 0, 0, "R5");
    // R5 unknown sixth address
    prefix("R5"); access(11'h70D, 0, 0, 0, "R5");
    // R6 restart on 0x000 after abort and on repeated 0x000
    access(11'h000, 0, 0, 0, "R6"); access(11'h555, 0, 0, 0, "R6");
    access(11'h123, 0, 0, 0, "R6");
    access(11'h000, 0, 0, 0, "R6");
    access(11'h000, 0, 0, 0, "R6"); access(11'h555, 0, 0, 0, "R6");
    access(11'h2AA, 0, 0, 0, "R6"); access(11'h7FF, 0, 0, 0, "R6");
    access(11'h0F0, 0, 0, 0, "R6"); access(11'h70E, 0, 0, 1, "R6");
    // R7 back at start after a command
    access(11'h555, 0, 0, 0, "R7"); access(11'h2AA, 0, 0, 0, "R7");
    access(11'h7FF, 0, 0, 0, "R7"); access(11'h0F0, 0, 0, 0, "R7");
    access(11'h70F, 0, 0, 0, "R7");
    // R8 output enable high throughout
    oe_n_i = 1'b1;
    prefix("R8"); access(11'h70F, 0, 1, 0, "R8");
    oe_n_i = 1'b0;
    // R10 inhibit blocks save, not restore; R7 start reached anyway
    save_inhibit_i = 1'b1;
    prefix("R10"); access(11'h70F, 0, 0, 0, "R10");
    access(11'h555, 0, 0, 0, "R7"); access(11'h2AA, 0, 0, 0, "R7");
    access(11'h7FF, 0, 0, 0, "R7"); access(11'h0F0, 0, 0, 0, "R7");
    access(11'h70E, 0, 0, 0, "R7");
    prefix("R10"); access(11'h70E, 0, 0, 1, "R10");
    save_inhibit_i = 1'b0;
    // R9 busy through a whole series
    busy_i = 1'b1;
    prefix("R9"); access(11'h70F, 0, 0, 0, "R9");
    // R9 busy over the first three steps, rest after release
    access(11'h000, 0, 0, 0, "R9"); access(11'h555, 0, 0, 0, "R9");
    access(11'h2AA, 0, 0, 0, "R9");
    busy_i = 1'b0;
    access(11'h7FF, 0, 0, 0, "R9"); access(11'h0F0, 0, 0, 0, "R9");
    access(11'h70E, 0, 0, 0, "R9");
    // R9 works again once released
    prefix("R9"); access(11'h70F, 0, 1, 0, "R9");

    repeat (6) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R11 scoreboard actual=%0d left expected=0", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule